// File: doc/BRIEF.md
# Subroutine Call Address Unit

This unit owns the program counter of a small 8-bit processor core and keeps the hardware return stack that sits beside it. Every cycle it picks the next fetch address. The choices are: the next sequential address, a subroutine target, a popped return address, or the current value held during a stall. Instruction memory and decode sit outside the unit. Decode hands it a two-bit operation code, an 11-bit immediate, the working register, the page latch register and a stall request.

There are two call forms. A direct call joins the immediate with two bits of the page latch. An indirect call joins the working register with seven bits of the page latch. Both forms save the address after the call on the return stack, and both take two cycles. In the second cycle the unit raises a flush output so the pipeline can discard the sequential instruction it has already fetched. The stack keeps the most recent return addresses in a ring. Pushing onto a full ring overwrites the oldest entry and produces an overflow pulse. Returning from an empty ring produces an underflow pulse.

Top module: `call_addr_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, pc_o is 0, depth_o is 0, empty_o is 1, and full_o, flush_o, ovf_o and unf_o are all 0.
- R2: op_i = 2'b01 (direct call), when accepted, loads pc_o with {2'b00, page_i[4:3], imm_i[10:0]} at the next clock edge.
- R3: op_i = 2'b10 (indirect call), when accepted, loads pc_o with {page_i[6:0], wreg_i[7:0]} at the next clock edge.
- R4: An accepted call of either form pushes (pc_o + 1) mod 2^15 onto the return stack and increments depth_o. A later return delivers that value.
- R5: In the cycle after an accepted call, flush_o is 1 and op_i is ignored. At the end of that cycle pc_o and depth_o are unchanged and flush_o drops.
- R6: op_i = 2'b11 (return), on a non-empty stack, loads pc_o with the most recently pushed address that has not yet been popped, and decrements depth_o.
- R7: A return on an empty stack raises unf_o for exactly one cycle, advances pc_o by one, and leaves depth_o at 0.
- R8: A call with depth_o = 16 raises ovf_o for one cycle and keeps depth_o at 16 with full_o = 1. The oldest entry is lost, so the 16 newest return addresses still pop in LIFO order.
- R9: With op_i = 2'b00 and no stall or flush, pc_o increments by one each cycle and wraps from 15'h7FFF to 0.
- R10: While stall_i is 1, pc_o, depth_o and flush_o hold their values, op_i is ignored, and ovf_o and unf_o read 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 2 | 00 sequential, 01 direct call, 10 indirect call, 11 return |
| imm_i | input | 11 | Direct call target offset |
| wreg_i | input | 8 | Working register, low byte of indirect target |
| page_i | input | 7 | Page latch register |
| stall_i | input | 1 | Freeze all state this cycle |
| pc_o | output | 15 | Current program counter |
| flush_o | output | 1 | Second call cycle; discard the fetched instruction |
| depth_o | output | 5 | Number of valid return stack entries |
| full_o | output | 1 | Return stack holds 16 entries |
| empty_o | output | 1 | Return stack holds no entries |
| ovf_o | output | 1 | One-cycle pulse: previous call overwrote the oldest entry |
| unf_o | output | 1 | One-cycle pulse: previous return found the stack empty |

## Verification
A wrong target or a wrong sequencing step shows up on pc_o one edge after the cause. A corrupted return stack slot or ring pointer stays hidden until the matching return, which may come many calls later. For that reason the stimulus fills the ring past capacity and then drains it completely, so every slot is read back. A depth counter that has drifted shows at once on depth_o, full_o and empty_o. A stuck busy state shows as flush_o staying high, or as pc_o freezing one cycle too many.

// File: rtl/cau_pkg.sv
package cau_pkg;

    localparam int CAU_PC_W      = 15;
    localparam int CAU_IMM_W     = 11;
    localparam int CAU_WREG_W    = 8;
    localparam int CAU_PAGE_W    = 7;
    localparam int CAU_STK_DEPTH = 16;

    typedef logic [CAU_PC_W-1:0]   pc_t;
    typedef logic [CAU_IMM_W-1:0]  imm_t;
    typedef logic [CAU_WREG_W-1:0] wreg_t;
    typedef logic [CAU_PAGE_W-1:0] page_t;

    typedef enum logic [1:0] {
        OP_SEQ      = 2'b00,
        OP_CALL_DIR = 2'b01,
        OP_CALL_IND = 2'b10,
        OP_RET      = 2'b11
    } op_e;

    typedef struct packed {
        logic push;
        logic pop;
        pc_t  wdata;
    } stk_req_t;

    // direct form: 13 meaningful bits, top two forced to zero
    function automatic pc_t dir_target(imm_t imm, page_t page);
        return {2'b00, page[4:3], imm};
    endfunction

    // indirect form: full 15 bits from page latch and working register
    function automatic pc_t ind_target(wreg_t wreg, page_t page);
        return {page, wreg};
    endfunction

endpackage

// File: rtl/cau_target.sv
module cau_target
    import cau_pkg::*;
(
    input  op_e   op_i,
    input  imm_t  imm_i,
    input  wreg_t wreg_i,
    input  page_t page_i,
    output pc_t   target_o
);

    always_comb begin
        if (op_i == OP_CALL_DIR) begin
            target_o = dir_target(imm_i, page_i);
        end else begin
            target_o = ind_target(wreg_i, page_i);
        end
    end

endmodule

// File: rtl/cau_stack.sv
module cau_stack #(
    parameter int DEPTH = 16,
    parameter int W     = 15
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push_i,
    input  logic                     pop_i,
    input  logic [W-1:0]             wdata_i,
    output logic [W-1:0]             top_o,
    output logic [$clog2(DEPTH):0]   count_o,
    output logic                     full_o,
    output logic                     empty_o
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] sp_q;      // next slot to write; ring of power-of-two size
    logic [CNT_W-1:0] cnt_q;

    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign count_o = cnt_q;
    assign top_o   = mem[sp_q - PTR_W'(1)];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_i && (sp_q == PTR_W'(g))) begin
                mem[g] <= wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q  <= '0;
            cnt_q <= '0;
        end else if (push_i) begin
            sp_q <= sp_q + PTR_W'(1);
            if (!full_o) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end else if (pop_i && !empty_o) begin
            sp_q  <= sp_q - PTR_W'(1);
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/call_addr_unit.sv
module call_addr_unit
    import cau_pkg::*;
#(
    parameter int STK_DEPTH = CAU_STK_DEPTH
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [1:0]                  op_i,
    input  logic [CAU_IMM_W-1:0]        imm_i,
    input  logic [CAU_WREG_W-1:0]       wreg_i,
    input  logic [CAU_PAGE_W-1:0]       page_i,
    input  logic                        stall_i,
    output logic [CAU_PC_W-1:0]         pc_o,
    output logic                        flush_o,
    output logic [$clog2(STK_DEPTH):0]  depth_o,
    output logic                        full_o,
    output logic                        empty_o,
    output logic                        ovf_o,
    output logic                        unf_o
);

    op_e      op;
    pc_t      pc_q, pc_d, pc_inc, target, stk_top;
    logic     busy_q, busy_d;
    logic     accept, is_call, is_ret;
    logic     ovf_q, unf_q, stk_full, stk_empty;
    stk_req_t req;

    assign op     = op_e'(op_i);
    assign pc_inc = pc_q + pc_t'(1);

    cau_target u_target (
        .op_i     (op),
        .imm_i    (imm_i),
        .wreg_i   (wreg_i),
        .page_i   (page_i),
        .target_o (target)
    );

    cau_stack #(.DEPTH(STK_DEPTH), .W(CAU_PC_W)) u_stack (
        .clk     (clk),
        .rst     (rst),
        .push_i  (req.push),
        .pop_i   (req.pop),
        .wdata_i (req.wdata),
        .top_o   (stk_top),
        .count_o (depth_o),
        .full_o  (stk_full),
        .empty_o (stk_empty)
    );

    always_comb begin
        accept    = !stall_i && !busy_q;
        is_call   = accept && (op == OP_CALL_DIR || op == OP_CALL_IND);
        is_ret    = accept && (op == OP_RET);
        req.push  = is_call;
        req.pop   = is_ret && !stk_empty;
        req.wdata = pc_inc;

        busy_d = stall_i ? busy_q : is_call;

        if (stall_i || busy_q) begin
            pc_d = pc_q;
        end else if (is_call) begin
            pc_d = target;
        end else if (req.pop) begin
            pc_d = stk_top;
        end else begin
            pc_d = pc_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            busy_q <= 1'b0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            pc_q   <= pc_d;
            busy_q <= busy_d;
            ovf_q  <= is_call && stk_full;
            unf_q  <= is_ret && stk_empty;
        end
    end

    assign pc_o    = pc_q;
    assign flush_o = busy_q;
    assign full_o  = stk_full;
    assign empty_o = stk_empty;
    assign ovf_o   = ovf_q;
    assign unf_o   = unf_q;

endmodule

// File: rtl/cau_checker.sv
module cau_checker
    import cau_pkg::*;
#(
    parameter int STK_DEPTH = CAU_STK_DEPTH
) (
    input logic                        clk,
    input logic                        rst,
    input logic [1:0]                  op_i,
    input logic [CAU_IMM_W-1:0]        imm_i,
    input logic [CAU_WREG_W-1:0]       wreg_i,
    input logic [CAU_PAGE_W-1:0]       page_i,
    input logic                        stall_i,
    input logic [CAU_PC_W-1:0]         pc_o,
    input logic                        flush_o,
    input logic [$clog2(STK_DEPTH):0]  depth_o,
    input logic                        full_o,
    input logic                        empty_o,
    input logic                        ovf_o,
    input logic                        unf_o
);

    logic go;
    assign go = !flush_o && !stall_i;

    p_dir_target_r2: assert property (@(posedge clk) disable iff (rst)
        (go && op_i == 2'b01) |=> (pc_o == {2'b00, $past(page_i[4:3]), $past(imm_i)}));

    p_ind_target_r3: assert property (@(posedge clk) disable iff (rst)
        (go && op_i == 2'b10) |=> (pc_o == {$past(page_i), $past(wreg_i)}));

    p_call_flush_r5: assert property (@(posedge clk) disable iff (rst)
        (go && op_i[1] != op_i[0]) |=> flush_o);

    p_flush_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (flush_o && !stall_i) |=> (!flush_o && $stable(pc_o) && $stable(depth_o)));

    p_empty_ret_r7: assert property (@(posedge clk) disable iff (rst)
        (go && op_i == 2'b11 && empty_o) |=> (unf_o && depth_o == '0));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        depth_o <= ($clog2(STK_DEPTH)+1)'(STK_DEPTH));

    p_full_call_r8: assert property (@(posedge clk) disable iff (rst)
        (go && op_i[1] != op_i[0] && full_o) |=> (ovf_o && full_o));

    p_seq_inc_r9: assert property (@(posedge clk) disable iff (rst)
        (go && op_i == 2'b00) |=> (pc_o == $past(pc_o) + 15'd1));

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> ($stable(pc_o) && $stable(depth_o) && $stable(flush_o) && !ovf_o && !unf_o));

    p_flags_excl_r1: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o));

endmodule

bind call_addr_unit cau_checker #(.STK_DEPTH(STK_DEPTH)) u_cau_checker (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .imm_i   (imm_i),
    .wreg_i  (wreg_i),
    .page_i  (page_i),
    .stall_i (stall_i),
    .pc_o    (pc_o),
    .flush_o (flush_o),
    .depth_o (depth_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o)
);

// File: tb/call_addr_unit_tb_top.sv
`timescale 1ns/1ps
module call_addr_unit_tb_top;
    import cau_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  op;
    logic [10:0] imm;
    logic [7:0]  wreg;
    logic [6:0]  page;
    logic        stall;
    logic [14:0] pc_o;
    logic        flush_o, full_o, empty_o, ovf_o, unf_o;
    logic [4:0]  depth_o;

    always #4 clk = ~clk;

    call_addr_unit dut_i (
        .clk(clk), .rst(rst), .op_i(op), .imm_i(imm), .wreg_i(wreg),
        .page_i(page), .stall_i(stall), .pc_o(pc_o), .flush_o(flush_o),
        .depth_o(depth_o), .full_o(full_o), .empty_o(empty_o),
        .ovf_o(ovf_o), .unf_o(unf_o)
    );

    int n_vec = 0;
    int n_bad = 0;

    // reference model: plain LIFO with shift-out of the oldest entry
    logic [14:0] m_pc;
    logic [14:0] m_stk [16];
    int          m_cnt;
    bit          m_busy, m_ovf, m_unf;
    string       m_tag;

    function automatic logic [14:0] exp_dir(logic [10:0] i, logic [6:0] p);
        return {2'b00, p[4:3], i};
    endfunction

    function automatic logic [14:0] exp_ind(logic [7:0] w, logic [6:0] p);
        return {p, w};
    endfunction

    task automatic m_push(input logic [14:0] v);
        if (m_cnt == 16) begin
            for (int i = 0; i < 15; i++) m_stk[i] = m_stk[i+1];
            m_stk[15] = v;
            m_ovf = 1'b1;
            m_tag = "R8";
        end else begin
            m_stk[m_cnt] = v;
            m_cnt++;
        end
    endtask

    task automatic m_step(input logic [1:0] o, input logic [10:0] i, input logic [7:0] w,
                          input logic [6:0] p, input bit st);
        m_ovf = 1'b0;
        m_unf = 1'b0;
        if (st) begin
            m_tag = "R10";
        end else if (m_busy) begin
            m_busy = 1'b0;
            m_tag  = "R5";
        end else begin
            case (o)
                2'b00: begin m_pc = m_pc + 15'd1; m_tag = "R9"; end
                2'b01: begin
                    m_tag = "R2 R4";
                    m_push(m_pc + 15'd1);
                    m_pc = exp_dir(i, p);
                    m_busy = 1'b1;
                end
                2'b10: begin
                    m_tag = "R3 R4";
                    m_push(m_pc + 15'd1);
                    m_pc = exp_ind(w, p);
                    m_busy = 1'b1;
                end
                default: begin
                    if (m_cnt == 0) begin
                        m_unf = 1'b1;
                        m_pc  = m_pc + 15'd1;
                        m_tag = "R7";
                    end else begin
                        m_cnt--;
                        m_pc  = m_stk[m_cnt];
                        m_tag = "R6";
                    end
                end
            endcase
        end
    endtask

    task automatic compare();
        bit ok;
        n_vec++;
        ok = (pc_o == m_pc) && (depth_o == 5'(m_cnt)) && (flush_o == m_busy) &&
             (ovf_o == m_ovf) && (unf_o == m_unf) &&
             (empty_o == (m_cnt == 0)) && (full_o == (m_cnt == 16));
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: pc=%h/%h depth=%0d/%0d flush=%0b/%0b ovf=%0b/%0b unf=%0b/%0b full=%0b empty=%0b (actual/expected)",
                     m_tag, pc_o, m_pc, depth_o, m_cnt, flush_o, m_busy,
                     ovf_o, m_ovf, unf_o, m_unf, full_o, empty_o);
        end
    endtask

    task automatic apply(input logic [1:0] o, input logic [10:0] i, input logic [7:0] w,
                         input logic [6:0] p, input bit st);
        op = o; imm = i; wreg = w; page = p; stall = st;
        @(posedge clk);
        m_step(o, i, w, p, st);
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        op = 2'b00; imm = '0; wreg = '0; page = '0; stall = 1'b0;
        repeat (3) @(posedge clk);
        m_pc = '0; m_cnt = 0; m_busy = 1'b0; m_ovf = 1'b0; m_unf = 1'b0;
        m_tag = "R1";
        @(negedge clk);
        compare();
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();                                   // R1
        apply(2'b00, 0, 0, 0, 0);                     // R9
        apply(2'b00, 0, 0, 0, 0);
        apply(2'b01, 11'h7FF, 8'h00, 7'h7F, 0);       // R2: top bits forced zero
        apply(2'b11, 0, 0, 0, 0);                     // R5: return ignored in flush cycle
        apply(2'b10, 0, 8'hFF, 7'h7F, 0);             // R3 -> 7FFF
        apply(2'b00, 0, 0, 0, 0);                     // R5
        apply(2'b00, 0, 0, 0, 0);                     // R9 wrap to 0
        apply(2'b01, 11'h123, 0, 7'h08, 0);           // call then stall inside flush (R10)
        apply(2'b11, 0, 0, 0, 1);
        apply(2'b11, 0, 0, 0, 1);
        apply(2'b00, 0, 0, 0, 0);
        apply(2'b11, 0, 0, 0, 0);                     // R6 pops
        apply(2'b11, 0, 0, 0, 0);
        apply(2'b11, 0, 0, 0, 0);
        apply(2'b11, 0, 0, 0, 0);                     // R7 empty
        apply(2'b11, 0, 0, 0, 1);                     // R10 stalled return
        apply(2'b11, 0, 0, 0, 0);                     // R7 again
        for (int k = 0; k < 18; k++) begin            // R8 overfill
            apply(2'b01, 11'(k * 97 + 5), 0, 7'(k), 0);
            apply(2'($urandom), 11'($urandom), 8'($urandom), 7'($urandom), 0);
        end
        for (int k = 0; k < 18; k++) apply(2'b11, 0, 0, 0, 0);  // R6 drain, R7 tail
        for (int k = 0; k < 4000; k++) begin
            int r;
            logic [1:0] o;
            r = int'($urandom % 100);
            o = (r < 40) ? 2'b00 : (r < 60) ? 2'b01 : (r < 75) ? 2'b10 : 2'b11;
            apply(o, 11'($urandom), 8'($urandom), 7'($urandom), ($urandom % 10) == 0);
        end
        do_reset();                                   // R1 after traffic
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule